// File: doc/BRIEF.md
# Audio Serial Clock Master Generator

This block produces the bit clock and the left/right frame clock of a two-channel serial audio port when the converter is the clock master. Both clocks are derived from the master clock. There are 64 bit-clock periods in each frame. The frame clock is low for the first 32 bits (left word) and high for the last 32 (right word). A one-cycle frame-start strobe tells the serial transmitter that a new left word begins.

The two clock pins are shared with configuration straps. After reset release, both output enables stay low for a fixed window of master-clock cycles. At the end of that window the block latches two strap levels:
- the level on the frame-clock pin picks single or double speed;
- the level on the bit-clock pin picks the ratio family (128/256/512 or 192/384/768).

One cycle later both pins become driven outputs. A separate high/low divider select doubles the master-clock-to-frame ratio inside the chosen speed mode. It is taken at the end of the strap window and afterwards only at each frame start.

The controller is a state machine with three states:
- `ST_WAIT` counts the strap window. It moves to `ST_ARM` on the last cycle of the window, which is the cycle in which the straps are latched.
- `ST_ARM` lasts one cycle and always moves to `ST_RUN`.
- `ST_RUN` holds until reset and enables the outputs.

Top module: `audio_clkgen`

## Requirements
- R1: During reset, and until the output enables rise, `sclk_oe`, `lrck_oe`, `sclk`, `lrck` and `frame_start` are all 0.
- R2: Counting rising master-clock edges after reset release, the straps are latched on edge 1024. Both output enables rise together on edge 1025 and then stay high until reset.
- R3: The frame-clock strap chooses the speed mode. A latched 0 gives single speed and a latched 1 gives double speed. Double speed halves the master-clock periods per frame.
- R4: The bit-clock strap chooses the ratio family. With 0, one bit lasts 2 master-clock cycles in double speed with the low divider. With 1, it lasts 3 cycles. The ratio family gives this base, single speed doubles it, and `div_hi`=1 doubles it again. The resulting cycles per bit are 2, 3, 4, 6, 8 or 12, which is 128 to 768 cycles per frame.
- R5: `div_hi` is taken when the straps are latched and again at each frame-clock falling edge. A change in the middle of a frame leaves the bit period unchanged until the next frame starts, and the new ratio applies from the first bit of that frame.
- R6: One frame-clock period equals 64 bit-clock periods.
- R7: The bit clock has a 50% duty cycle for every ratio, including the 3-cycle bit: high for N/2 master-clock periods out of N.
- R8: The frame clock is low for 32 bits and high for 32 bits. It changes only at the same instant as a bit-clock falling edge.
- R9: `frame_start` is high for exactly one master-clock cycle at each frame-clock falling edge, and never at any other time.
- R10: Strap inputs are ignored once latched. Changing them while running alters neither the bit-clock nor the frame-clock period.
- R11: When the outputs are enabled, the frame clock starts high and the bit clock starts low. The first frame-clock falling edge comes 32 bit periods after the enables rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_lr_level | input | 1 | Level seen on the frame-clock pin during the strap window (0 single, 1 double speed) |
| strap_bit_level | input | 1 | Level seen on the bit-clock pin during the strap window (0 for the 128 family, 1 for the 192 family) |
| div_hi | input | 1 | High divider select (1 doubles the ratio) |
| sclk | output | 1 | Bit clock, 64 per frame |
| lrck | output | 1 | Frame clock, low for the left word |
| sclk_oe | output | 1 | Drive enable for the bit-clock pin |
| lrck_oe | output | 1 | Drive enable for the frame-clock pin |
| frame_start | output | 1 | One-cycle strobe at each frame-clock falling edge |

## Verification
Six strap and divider combinations are applied from reset: 2, 3, 4, 6, 8 and 12 master-clock cycles per bit. Each one is identified by its measured bit-clock period and high time, and by the frame-clock period. The 3-cycle case is the only one that exposes the half-cycle edge of the odd divider. Each run also checks that the enables stay low through the strap window and rise on the expected edge, and that the first frame-clock fall comes 32 bits later. A run with straps flipped after latching, and a divider change made mid-frame, separate configuration that is latched once from configuration that is re-taken at each frame boundary.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } acg_state_e;

    // Master-clock cycles per bit: family base, x2 in single speed, x2 with the high divider.
    function automatic int unsigned cycles_per_bit(
        input int unsigned base_lo,
        input int unsigned base_hi,
        input logic        fam_hi,
        input logic        dbl_speed,
        input logic        hdiv
    );
        int unsigned n;
        n = fam_hi ? base_hi : base_lo;
        if (!dbl_speed) n = n * 2;
        if (hdiv)       n = n * 2;
        return n;
    endfunction

endpackage

// File: rtl/acg_ctrl.sv
module acg_ctrl
    import audio_clkgen_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_speed,
    input  logic strap_family,
    output logic cfg_dbl,
    output logic cfg_fam,
    output logic load,
    output logic run
);

    localparam int unsigned WCW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    acg_state_e         state_q, state_d;
    logic [WCW-1:0]     wcnt_q;
    logic               wdone;

    assign wdone = (wcnt_q == WCW'(WAIT_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (wdone) state_d = ST_ARM;
            ST_ARM:  state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            ST_WAIT: load = wdone;
            ST_ARM:  run  = 1'b0;
            ST_RUN:  run  = 1'b1;
            default: run  = 1'b0;
        endcase
    end

    // strap window counter and strap latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            cfg_dbl <= 1'b0;
            cfg_fam <= 1'b0;
        end else begin
            if (state_q == ST_WAIT && !wdone) wcnt_q <= wcnt_q + 1'b1;
            if (load) begin
                cfg_dbl <= strap_speed;
                cfg_fam <= strap_family;
            end
        end
    end

endmodule

// File: rtl/acg_bit_div.sv
module acg_bit_div #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] div,
    output logic          sclk,
    output logic          wrap
);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   half_up;
    logic          hi_pos;
    logic          hi_neg_q;
    logic          odd;

    assign odd     = div[0];
    assign half_up = ({1'b0, div} + 1'b1) >> 1;
    assign wrap    = run && (cnt_q == div - 1'b1);
    assign hi_pos  = ({1'b0, cnt_q} >= half_up);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!run)      cnt_q <= '0;
        else if (wrap)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // Half-cycle extension for odd ratios: rise in the middle of the centre cycle.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hi_neg_q <= 1'b0;
        else        hi_neg_q <= run && odd && (cnt_q == (div >> 1));
    end

    assign sclk = run && (hi_pos || hi_neg_q);

endmodule

// File: rtl/acg_frame.sv
module acg_frame #(
    parameter int unsigned BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    input  logic load,
    input  logic div_in,
    output logic lrck,
    output logic frame_start,
    output logic div_sel
);

    localparam int unsigned BW = $clog2(BITS);

    logic [BW-1:0] bcnt_q;
    logic          last_bit;
    logic          boundary;

    assign last_bit = (bcnt_q == BW'(BITS - 1));
    assign boundary = run && wrap && last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q      <= BW'(BITS / 2);
            frame_start <= 1'b0;
            div_sel     <= 1'b0;
        end else begin
            if (!run)      bcnt_q <= BW'(BITS / 2);
            else if (wrap) bcnt_q <= bcnt_q + 1'b1;
            frame_start <= boundary;
            if (load || boundary) div_sel <= div_in;
        end
    end

    assign lrck = run && bcnt_q[BW-1];

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int unsigned WAIT_CYC    = 1024,
    parameter int unsigned BITS_FRAME  = 64,
    parameter int unsigned DIV_BASE_LO = 2,
    parameter int unsigned DIV_BASE_HI = 3
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic strap_lr_level,
    input  logic strap_bit_level,
    input  logic div_hi,
    output logic sclk,
    output logic lrck,
    output logic sclk_oe,
    output logic lrck_oe,
    output logic frame_start
);

    localparam int unsigned MAX_DIV = 4 * ((DIV_BASE_HI > DIV_BASE_LO) ? DIV_BASE_HI : DIV_BASE_LO);
    localparam int unsigned CW      = $clog2(MAX_DIV + 1);

    logic          cfg_dbl, cfg_fam, load, run;
    logic          div_sel, wrap;
    logic [CW-1:0] div;

    acg_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
        .clk          (mclk),
        .rst_n        (rst_n),
        .strap_speed  (strap_lr_level),
        .strap_family (strap_bit_level),
        .cfg_dbl      (cfg_dbl),
        .cfg_fam      (cfg_fam),
        .load         (load),
        .run          (run)
    );

    always_comb begin
        div = CW'(cycles_per_bit(DIV_BASE_LO, DIV_BASE_HI, cfg_fam, cfg_dbl, div_sel));
    end

    acg_bit_div #(.CW(CW)) u_bit (
        .clk   (mclk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div),
        .sclk  (sclk),
        .wrap  (wrap)
    );

    acg_frame #(.BITS(BITS_FRAME)) u_frame (
        .clk         (mclk),
        .rst_n       (rst_n),
        .run         (run),
        .wrap        (wrap),
        .load        (load),
        .div_in      (div_hi),
        .lrck        (lrck),
        .frame_start (frame_start),
        .div_sel     (div_sel)
    );

    assign sclk_oe = run;
    assign lrck_oe = run;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic mclk,
    input logic rst_n,
    input logic sclk,
    input logic lrck,
    input logic sclk_oe,
    input logic lrck_oe,
    input logic frame_start
);

    AST_OE_MATCH: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_oe == lrck_oe); // R2

    AST_OE_HOLD: assert property (@(posedge mclk) disable iff (!rst_n)
        sclk_oe |=> sclk_oe); // R2

    AST_QUIET_PRE: assert property (@(posedge mclk) disable iff (!rst_n)
        !sclk_oe |-> (!sclk && !lrck && !frame_start)); // R1

    AST_FS_ONE_CYCLE: assert property (@(posedge mclk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R9

    AST_FS_ON_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        frame_start |-> $fell(lrck)); // R9

    AST_FALL_HAS_FS: assert property (@(posedge mclk) disable iff (!rst_n)
        ($fell(lrck) && $past(sclk_oe)) |-> frame_start); // R9

    AST_LRCK_ON_SCLK_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
        (($rose(lrck) || $fell(lrck)) && $past(sclk_oe)) |-> $fell(sclk)); // R8

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .lrck        (lrck),
    .sclk_oe     (sclk_oe),
    .lrck_oe     (lrck_oe),
    .frame_start (frame_start)
);

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;

    logic mclk = 1'b0;
    always #10 mclk = ~mclk;

    logic rst_n = 1'b0;
    logic s_lr = 1'b0, s_bit = 1'b0, dhi = 1'b0;
    logic sclk, lrck, soe, loe, fs;

    int total = 0;
    int bad   = 0;
    realtime t_sfall = 0.0;

    audio_clkgen u0 (
        .mclk            (mclk),
        .rst_n           (rst_n),
        .strap_lr_level  (s_lr),
        .strap_bit_level (s_bit),
        .div_hi          (dhi),
        .sclk            (sclk),
        .lrck            (lrck),
        .sclk_oe         (soe),
        .lrck_oe         (loe),
        .frame_start     (fs)
    );

    always @(negedge sclk) t_sfall = $realtime;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic power_up(input bit lr, input bit bt, input bit hi, input int n);
        int viol = 0;
        realtime ten, tf;
        s_lr = lr; s_bit = bt; dhi = hi; rst_n = 1'b0;
        repeat (3) @(negedge mclk);
        check(!soe && !loe && !sclk && !lrck && !fs, "R1 reset state",
              int'({soe, loe, sclk, lrck, fs}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            @(negedge mclk);
            if (soe || loe || sclk || lrck || fs) viol++;
        end
        check(viol == 0, "R1 outputs quiet through edge 1024", viol, 0);
        @(negedge mclk);
        check(soe && loe, "R2 enables high after edge 1025", int'({soe, loe}), 3);
        check(lrck && !sclk, "R11 start levels lrck/sclk", int'({lrck, sclk}), 2);
        ten = $realtime - 10.0;
        @(negedge lrck);
        tf = $realtime;
        check(int'(tf - ten) == 32 * n * 20, "R11 first frame fall time",
              int'(tf - ten), 32 * n * 20);
    endtask

    task automatic measure(input int n, input string tag);
        realtime a, b, c;
        int cnt = 0;
        @(posedge sclk); a = $realtime;
        @(negedge sclk); b = $realtime;
        @(posedge sclk); c = $realtime;
        check(int'(c - a) == n * 20, {tag, " R7 bit period"}, int'(c - a), n * 20);
        check(int'(b - a) == n * 10, {tag, " R7 bit high time"}, int'(b - a), n * 10);
        @(negedge lrck); a = $realtime;
        @(posedge lrck); b = $realtime;
        @(negedge lrck); c = $realtime;
        check(int'(c - a) == 64 * n * 20, {tag, " R6 frame period"}, int'(c - a), 64 * n * 20);
        check(int'(c - b) == 32 * n * 20, {tag, " R8 frame high time"}, int'(c - b), 32 * n * 20);
        #1;
        check(t_sfall == c, {tag, " R8 frame edge on bit fall"}, int'(t_sfall), int'(c));
        check(fs == 1'b1, {tag, " R9 strobe at frame fall"}, int'(fs), 1);
        repeat (64 * n) begin
            @(negedge mclk);
            if (fs) cnt++;
        end
        check(cnt == 1, {tag, " R9 one strobe cycle per frame"}, cnt, 1);
    endtask

    task automatic t_single_256;
        power_up(1'b0, 1'b0, 1'b0, 4);
        measure(4, "R3 R4 single 256x");
    endtask

    task automatic t_strap_ignore;
        s_lr = 1'b1; s_bit = 1'b1;
        measure(4, "R10 straps flipped while running");
    endtask

    task automatic t_div_switch;
        realtime a, b, c;
        @(posedge lrck); #3;
        dhi = 1'b1;
        @(posedge sclk); a = $realtime;
        @(posedge sclk); b = $realtime;
        check(int'(b - a) == 80, "R5 mid-frame change not applied", int'(b - a), 80);
        @(negedge lrck); a = $realtime;
        @(posedge sclk); b = $realtime;
        @(negedge sclk); c = $realtime;
        check(int'(b - a) == 80, "R5 new ratio low half at frame start", int'(b - a), 80);
        check(int'(c - a) == 160, "R5 new ratio first bit period", int'(c - a), 160);
        measure(8, "R5 after switch 512x");
    endtask

    task automatic t_single_768;
        power_up(1'b0, 1'b1, 1'b1, 12);
        measure(12, "R4 R5 single 768x");
    endtask

    task automatic t_double_128;
        power_up(1'b1, 1'b0, 1'b0, 2);
        measure(2, "R3 double 128x");
    endtask

    task automatic t_double_192;
        power_up(1'b1, 1'b1, 1'b0, 3);
        measure(3, "R4 R7 double 192x odd divide");
    endtask

    task automatic t_double_384;
        power_up(1'b1, 1'b1, 1'b1, 6);
        measure(6, "R4 R5 double 384x");
    endtask

    initial begin
        #(150000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_single_256();
        t_strap_ignore();
        t_div_switch();
        t_single_768();
        t_double_128();
        t_double_192();
        t_double_384();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule